// File: doc/BRIEF.md
# UART FIFO and Interrupt Controller

This block buffers bytes between a simple register bus and a serial transceiver. It holds two independent byte queues: one for outgoing bytes, filled by bus writes and drained by the transceiver, and one for incoming bytes, filled by the transceiver and drained by bus reads. A single data address serves both queues. A write to it enqueues an outgoing byte, and a read from it dequeues the oldest incoming byte. Software can poll full and empty bits in a status register. Software can also program a fill threshold for the incoming queue.

Four conditions are latched as interrupt flags: a receive error, receive fill at or above the threshold, an empty transmit queue, and a dropped byte (overflow). The single interrupt line is the OR of each latched flag gated by its enable bit. Reading the flag register returns the flags and clears them. A flag whose condition is still present latches again on the following clock.

The transmit side leaves the block as a valid/ready stream. A byte is transferred on every clock where both valid and ready are high. The transceiver may hold `tx_ready` low for any number of cycles. While it does, `tx_data` stays unchanged. The receive side enters as a valid stream with an advisory `rx_ready`. A byte presented while `rx_ready` is low is not held back. It is dropped and counted as an overflow. Bus accesses are single-cycle. Read data is combinational during the cycle `bus_rd` is high, and the side effects of the read take place at the closing clock edge.

Top module: `uart_fifo_irq`

## Requirements
- R1: The transmit and receive queues are independent, each holds DEPTH bytes (default 2048), and each returns bytes in the order they entered.
- R2: Address 0 is the data port. A write enqueues `bus_wdata[7:0]` for transmit. A read returns the oldest received byte in bits 7:0 and removes it. A read of an empty receive queue returns 0 and removes nothing.
- R3: Address 1 is status: bit0 transmit full, bit1 receive empty, bit2 transmit empty, bit3 receive full. All other bits read 0.
- R4: Address 2 is the threshold. A written value of 0 is stored as 1, and a value above DEPTH is stored as DEPTH. A read returns the stored value. After reset the threshold is 1 and the enable register (address 3) is 0.
- R5: Flag bit1 latches when the receive fill level is at or above the threshold. It appears one clock after the level is reached.
- R6: Flag bit0 latches on an `rx_err` pulse. Flag bit2 latches while the transmit queue is empty.
- R7: A data write while the transmit queue is full, or an `rx_valid` byte while the receive queue is full, is dropped. The queue contents stay unchanged and flag bit3 latches.
- R8: Address 4 is the flag register. A read returns the flags in bits 3:0 and clears them. An `rx_err` or overflow event in the read cycle stays latched. A level condition that still holds latches again one clock later.
- R9: `irq` is high exactly when some latched flag has its bit set in the enable register (address 3, bits 3:0 in flag order). Bit1 enables the threshold interrupt.
- R10: Any write to address 5 empties both queues and clears all flags at that edge.
- R11: `tx_valid` is high whenever the transmit queue is non-empty, and `tx_data` shows the oldest byte. The byte is removed on a clock where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_data` holds.
- R12: `rx_ready` is high exactly when the receive queue is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid while bus_rd is high |
| tx_valid | output | 1 | Outgoing byte available |
| tx_ready | input | 1 | Transceiver accepts outgoing byte |
| tx_data | output | 8 | Outgoing byte |
| rx_valid | input | 1 | Incoming byte present |
| rx_ready | output | 1 | Receive queue has room |
| rx_data | input | 8 | Incoming byte |
| rx_err | input | 1 | One-cycle receive error pulse |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the inputs:
- `bus_wr` and `bus_rd` are never high in the same cycle.
- `rx_err` is a one-cycle pulse.
- DEPTH is a power of two, at least 2.

The bench keeps to these assumptions. It issues bus accesses one per task, each spanning exactly one cycle, and it raises `rx_err` for a single cycle at a time. It runs an eight-entry configuration. That size lets every threshold setting be swept against every fill level, and lets every written threshold value in 0..15 be checked against its clamped readback.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  typedef enum logic [2:0] {
    ADDR_DATA  = 3'd0,
    ADDR_STAT  = 3'd1,
    ADDR_THR   = 3'd2,
    ADDR_IEN   = 3'd3,
    ADDR_IFLAG = 3'd4,
    ADDR_CMD   = 3'd5
  } reg_addr_e;

  localparam int NFLAG     = 4;
  localparam int FL_RXERR  = 0;
  localparam int FL_THRESH = 1;
  localparam int FL_TXEMPT = 2;
  localparam int FL_OVF    = 3;
  // flags fed by one-cycle events survive a read in the same cycle
  localparam logic [NFLAG-1:0] EVENT_MASK = 4'b1001;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [7:0]    push_data,
  input  logic          pop,
  output logic [7:0]    head,
  output logic [CW-1:0] count
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, empty, do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R1
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (count == CW'(DEPTH)) && $stable(wr_ptr)); // R7
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0)); // R10
endmodule

// File: rtl/irq_flags.sv
module irq_flags
  import uart_fifo_pkg::*;
#(
  parameter logic [NFLAG-1:0] EVT = EVENT_MASK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_all,
  input  logic             rd_clear,
  input  logic [NFLAG-1:0] cond,
  input  logic [NFLAG-1:0] enable,
  output logic [NFLAG-1:0] flags,
  output logic             irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flags <= '0;
    else if (clear_all) flags <= '0;
    else if (rd_clear)  flags <= cond & EVT;
    else                flags <= flags | cond;
  end

  assign irq = |(flags & enable);

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clear && !clear_all) |=> ((flags & ~EVT) == '0)); // R8
  AST_LEVEL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cond[FL_THRESH] && !rd_clear && !clear_all) |=> flags[FL_THRESH]); // R5
  AST_CMD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> (flags == '0)); // R10
endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int DW = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    rx_data,
  input  logic          rx_err,
  output logic          irq
);
  logic [CW-1:0]    tx_count, rx_count, thresh;
  logic [7:0]       rx_head;
  logic [NFLAG-1:0] ien, flags, cond;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic             data_wr, data_rd, cmd_wr, flag_rd;

  assign data_wr = bus_wr && (bus_addr == ADDR_DATA);
  assign data_rd = bus_rd && (bus_addr == ADDR_DATA);
  assign cmd_wr  = bus_wr && (bus_addr == ADDR_CMD);
  assign flag_rd = bus_rd && (bus_addr == ADDR_IFLAG);

  byte_fifo #(.DEPTH(DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(cmd_wr),
    .push(data_wr), .push_data(bus_wdata[7:0]),
    .pop(tx_ready), .head(tx_data), .count(tx_count));

  byte_fifo #(.DEPTH(DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(cmd_wr),
    .push(rx_valid), .push_data(rx_data),
    .pop(data_rd), .head(rx_head), .count(rx_count));

  assign tx_full  = (tx_count == CW'(DEPTH));
  assign tx_empty = (tx_count == '0);
  assign rx_full  = (rx_count == CW'(DEPTH));
  assign rx_empty = (rx_count == '0);
  assign tx_valid = !tx_empty;
  assign rx_ready = !rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thresh <= CW'(1);
      ien    <= '0;
    end else if (bus_wr) begin
      if (bus_addr == ADDR_THR) begin
        if (bus_wdata == '0)               thresh <= CW'(1);
        else if (bus_wdata > DW'(DEPTH))   thresh <= CW'(DEPTH);
        else                               thresh <= bus_wdata[CW-1:0];
      end
      if (bus_addr == ADDR_IEN) ien <= bus_wdata[NFLAG-1:0];
    end
  end

  always_comb begin
    cond            = '0;
    cond[FL_RXERR]  = rx_err;
    cond[FL_THRESH] = (rx_count >= thresh);
    cond[FL_TXEMPT] = tx_empty;
    cond[FL_OVF]    = (data_wr && tx_full) || (rx_valid && rx_full);
  end

  irq_flags u_flags (
    .clk(clk), .rst_n(rst_n), .clear_all(cmd_wr), .rd_clear(flag_rd),
    .cond(cond), .enable(ien), .flags(flags), .irq(irq));

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        ADDR_DATA:  bus_rdata = rx_empty ? '0 : DW'(rx_head);
        ADDR_STAT:  bus_rdata = DW'({rx_full, tx_empty, rx_empty, tx_full});
        ADDR_THR:   bus_rdata = DW'(thresh);
        ADDR_IEN:   bus_rdata = DW'(ien);
        ADDR_IFLAG: bus_rdata = DW'(flags);
        default:    bus_rdata = '0;
      endcase
    end
  end

  AST_THRESH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (thresh >= CW'(1)) && (thresh <= CW'(DEPTH))); // R4
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !cmd_wr) |=> (tx_valid && $stable(tx_data))); // R11
  AST_NO_RD_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr)); // R2
endmodule

// File: tb/test_uart_fifo_irq.sv
module test_uart_fifo_irq;
  localparam int DEPTH = 8;
  localparam int DW = 16;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_addr = 0;
  logic [DW-1:0] bus_wdata = 0, bus_rdata;
  logic tx_valid, tx_ready = 0, rx_valid = 0, rx_ready, rx_err = 0, irq;
  logic [7:0] tx_data, rx_data = 0;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  uart_fifo_irq #(.DEPTH(DEPTH), .DW(DW)) i_uart_fifo_irq (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_err(rx_err), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [DW-1:0] v);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic push_rx(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(negedge clk); rx_valid = 0;
  endtask

  function automatic logic [7:0] txb(input int i); return 8'((i * 37 + 5) & 255); endfunction
  function automatic logic [7:0] rxb(input int i); return 8'((i * 53 + 11) & 255); endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R3 reset status", 32'(bus_rdata), 0);
    bus_rd = 1; bus_addr = 3'd1; #1 chk("R3 reset status", 32'(bus_rdata), 32'h6); bus_rd = 0;
    chk("R9 reset irq", 32'(irq), 0);
    chk("R11 reset tx_valid", 32'(tx_valid), 0);
    chk("R12 reset rx_ready", 32'(rx_ready), 1);
    bus_read(3'd2, v); chk("R4 reset threshold", 32'(v), 1);
    bus_read(3'd3, v); chk("R4 reset enable", 32'(v), 0);
    bus_read(3'd4, v); chk("R6 tx empty flag", 32'(v), 32'h4);

    // transmit fill and overflow
    for (int i = 0; i < DEPTH; i++) bus_write(3'd0, DW'(txb(i)));
    bus_read(3'd1, v); chk("R3 tx full status", 32'(v), 32'h3);
    bus_write(3'd0, 16'h00EE);
    bus_read(3'd4, v); chk("R7 overflow flag on tx", 32'(v), 32'hC);
    // stall holds head
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R11 stall hold", {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, txb(0)});
    end
    tx_ready = 1;
    for (int k = 0; k < DEPTH; k++) begin
      chk("R11 R1 tx order", {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, txb(k)});
      @(negedge clk);
    end
    tx_ready = 0;
    chk("R7 dropped tx byte absent", 32'(tx_valid), 0);

    // receive fill, overflow, readout
    for (int i = 0; i < DEPTH; i++) push_rx(rxb(i));
    chk("R12 rx_ready full", 32'(rx_ready), 0);
    push_rx(8'hAA);
    bus_read(3'd1, v); chk("R3 rx full status", 32'(v), 32'hC);
    for (int i = 0; i < DEPTH; i++) begin
      bus_read(3'd0, v); chk("R2 R1 rx order", 32'(v), 32'(rxb(i)));
    end
    bus_read(3'd0, v); chk("R2 empty read", 32'(v), 0);
    bus_read(3'd1, v); chk("R3 both empty", 32'(v), 32'h6);

    // threshold clamp sweep
    for (int w = 0; w < 16; w++) begin
      bus_write(3'd2, DW'(w));
      bus_read(3'd2, v);
      chk("R4 clamp", 32'(v), (w == 0) ? 1 : (w > DEPTH) ? DEPTH : w);
    end
    bus_write(3'd2, 16'hFFFF);
    bus_read(3'd2, v); chk("R4 clamp max", 32'(v), DEPTH);

    // threshold vs fill level sweep
    bus_write(3'd3, 16'h2);
    for (int th = 1; th <= DEPTH; th++) begin
      bus_write(3'd5, 0);
      bus_write(3'd2, DW'(th));
      chk("R5 below threshold", 32'(irq), 0);
      for (int n = 1; n <= DEPTH; n++) begin
        push_rx(8'(n));
        @(negedge clk);
        chk("R5 R9 threshold irq", 32'(irq), (n >= th) ? 1 : 0);
      end
    end
    bus_read(3'd4, v); chk("R8 flag read value", 32'(v), 32'h6);
    chk("R8 cleared after read", 32'(irq), 0);
    @(negedge clk);
    chk("R8 relatch", 32'(irq), 1);
    bus_write(3'd3, 16'h0);
    chk("R9 masked", 32'(irq), 0);

    // receive error
    bus_write(3'd5, 0);
    bus_write(3'd3, 16'h1);
    @(negedge clk); rx_err = 1;
    @(negedge clk); rx_err = 0;
    chk("R6 R9 rx_err irq", 32'(irq), 1);
    bus_read(3'd4, v); chk("R6 rx_err flag", 32'(v), 32'h5);
    bus_read(3'd4, v); chk("R8 rx_err cleared", 32'(v), 32'h4);
    chk("R8 irq after clear", 32'(irq), 0);
    @(negedge clk); bus_rd = 1; bus_addr = 3'd4; rx_err = 1;
    @(negedge clk); bus_rd = 0; rx_err = 0;
    bus_read(3'd4, v); chk("R8 event during read kept", 32'(v & 1), 1);

    // overflow interrupt and command
    bus_write(3'd3, 16'h8);
    for (int i = 0; i <= DEPTH; i++) bus_write(3'd0, DW'(i));
    chk("R7 R9 overflow irq", 32'(irq), 1);
    push_rx(8'h11);
    bus_write(3'd5, 0);
    chk("R10 irq cleared", 32'(irq), 0);
    chk("R10 tx emptied", 32'(tx_valid), 0);
    bus_read(3'd1, v); chk("R10 status", 32'(v), 32'h6);
    bus_read(3'd4, v); chk("R10 flags cleared", 32'(v), 32'h4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule